// File: doc/BRIEF.md
# Bus Target Command and Configuration Decoder

This block sits behind the address/data pins of a single-function bus target on a parallel PCI or PCI-X bus. On the clock edge where the start of a transaction (FRAME# low) is first seen, it samples the command nibble, the low address lines and the IDSEL select line. It decides whether the device claims the cycle, and turns the command into a canonical operation code. The two reserved alias commands are folded onto their block counterparts, and the block transfer commands are gated by the bus mode.

For configuration cycles it also extracts the 6-bit dword register index. On the following edge, which is the first data phase, it captures the byte-lane enables. All results are held steady until the bus returns to idle, when FRAME# and IRDY# are both deasserted. A cycle that is not claimed leaves the claim flag low, so the initiator master-aborts. Bus handshaking, parity and the register file are outside this block.

Top module: `bus_target_decoder`

## Requirements
- R1: Configuration read (command 1010) and configuration write (command 1011) are claimed only if IDSEL is high and ad[1:0] equal 00 at the address edge.
- R2: A configuration cycle is claimed only when the function number in ad[10:8] is 000.
- R3: For a claimed configuration cycle, reg_idx equals ad[7:2] as sampled at the address edge. For every other cycle it is 0.
- R4: byte_en equals the bitwise inverse of cbe_n sampled on the edge after the address edge (active-high lanes) when the cycle is claimed. Otherwise it is 0.
- R5: Address bits ad[63:11] have no effect on any output.
- R6: Command 0111 (memory write) is claimed in both bus modes, regardless of IDSEL. The op encodings are: 0 none, 1 configuration read, 2 configuration write, 3 memory write, 4 memory read block, 5 memory write block.
- R7: Command 1000 decodes exactly as 1110 (op 4), and command 1001 decodes exactly as 1111 (op 5).
- R8: Commands 1000, 1001, 1110 and 1111 are claimed only when pci_x_mode is high at the address edge.
- R9: Any other command, or any cycle that fails its decode rule, gives claim low and op 0.
- R10: claim, op and reg_idx are registered on the edge where frame_n is low with no transaction in progress. Once registered, all outputs stay stable until the edge where frame_n and irdy_n are both high. At that edge all outputs clear to 0.
- R11: While rst_n is low at a clock edge, all outputs become 0 and any transaction in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this device |
| pci_x_mode | input | 1 | High when the bus runs in PCI-X mode |
| ad | input | 64 | Address/data lines |
| cbe_n | input | 4 | Command (address phase) / byte enables (data phase), active low |
| claim | output | 1 | Device accepts this cycle |
| op | output | 3 | Canonical operation code |
| reg_idx | output | 6 | Configuration dword register index |
| byte_en | output | 4 | Active-high byte-lane enables |

## Verification
claim, op and reg_idx are due one edge after the address is driven. byte_en is due one edge after the data-phase byte enables are driven. The clear is due on the edge after frame_n and irdy_n both rise. The bench drives every phase at the falling edge and samples each result at the next falling edge after the edge that produces it, so each check sits exactly one register stage behind its stimulus. A long transaction changes ad, cbe_n and idsel while frame_n stays low, to show that the held outputs do not move.

// File: rtl/bus_target_pkg.sv
// Shared types for the bus target decoder.
// Assumes the 4-bit command nibble of a parallel PCI/PCI-X bus.
package bus_target_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_CFG_RD   = 3'd1,
        OP_CFG_WR   = 3'd2,
        OP_MEM_WR   = 3'd3,
        OP_BLK_RD   = 3'd4,
        OP_BLK_WR   = 3'd5
    } op_e;

    localparam logic [3:0] CMD_MEM_WR    = 4'b0111;
    localparam logic [3:0] CMD_ALIAS_RD  = 4'b1000;
    localparam logic [3:0] CMD_ALIAS_WR  = 4'b1001;
    localparam logic [3:0] CMD_CFG_RD    = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR    = 4'b1011;
    localparam logic [3:0] CMD_BLK_RD    = 4'b1110;
    localparam logic [3:0] CMD_BLK_WR    = 4'b1111;

endpackage

// File: rtl/cfg_addr_check.sv
// Checks the address phase of a configuration cycle: the device must be
// selected, the access type bits must be 00, and the function number must
// match the single implemented function. Higher address bits are ignored.
// Assumes FUNC_W + 8 <= width of the address slice handed in.
module cfg_addr_check #(
    parameter int FUNC_W   = 3,
    parameter int IDX_W    = 6,
    parameter int MY_FUNC  = 0,
    localparam int LOW_W   = 2 + IDX_W + FUNC_W
) (
    input  logic              idsel,
    input  logic [LOW_W-1:0]  ad_low,
    output logic              cfg_hit,
    output logic [IDX_W-1:0]  cfg_idx
);

    localparam int FUNC_LSB = 2 + IDX_W;

    // Combine select, type bits and function number into one hit flag.
    always_comb begin
        cfg_hit = idsel
               && (ad_low[1:0] == 2'b00)
               && (ad_low[LOW_W-1:FUNC_LSB] == FUNC_W'(MY_FUNC));
        cfg_idx = ad_low[FUNC_LSB-1:2];
    end

endmodule

// File: rtl/cmd_classifier.sv
// Maps a command nibble onto a canonical operation, folding the alias
// commands onto the block commands and gating block transfers by bus mode.
// Assumes cfg_hit already reflects the configuration address rules.
module cmd_classifier
    import bus_target_pkg::*;
(
    input  logic [3:0] cmd,
    input  logic       pcix,
    input  logic       cfg_hit,
    output logic       accept,
    output op_e        op
);

    // Decode command, mode and address qualification into accept + op.
    always_comb begin
        accept = 1'b0;
        op     = OP_NONE;
        unique case (cmd)
            CMD_CFG_RD: if (cfg_hit) begin accept = 1'b1; op = OP_CFG_RD; end
            CMD_CFG_WR: if (cfg_hit) begin accept = 1'b1; op = OP_CFG_WR; end
            CMD_MEM_WR: begin accept = 1'b1; op = OP_MEM_WR; end
            CMD_BLK_RD, CMD_ALIAS_RD: if (pcix) begin accept = 1'b1; op = OP_BLK_RD; end
            CMD_BLK_WR, CMD_ALIAS_WR: if (pcix) begin accept = 1'b1; op = OP_BLK_WR; end
            default: begin accept = 1'b0; op = OP_NONE; end
        endcase
    end

endmodule

// File: rtl/phase_tracker.sv
// Tracks the bus transaction: flags the address edge, the first data edge
// and the return to idle. Assumes frame_n/irdy_n are already synchronous.
module phase_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic addr_edge,
    output logic data_edge,
    output logic end_edge,
    output logic busy
);

    logic first_data;

    // Edge qualifiers seen by the output registers.
    always_comb begin
        addr_edge = !busy && !frame_n;
        end_edge  = busy && frame_n && irdy_n;
        data_edge = busy && first_data && !end_edge;
    end

    // Busy/first-data state across the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            first_data <= 1'b0;
        end else if (addr_edge) begin
            busy       <= 1'b1;
            first_data <= 1'b1;
        end else if (end_edge) begin
            busy       <= 1'b0;
            first_data <= 1'b0;
        end else if (data_edge) begin
            first_data <= 1'b0;
        end
    end

    AST_ADDR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_edge |=> busy); // R10
    AST_END_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_edge |=> !busy); // R10

endmodule

// File: rtl/bus_target_decoder.sv
// Address-phase decoder for a single-function bus target. Registers the
// claim, operation and configuration register index at the address edge,
// the byte lanes at the first data edge, and clears everything when the
// bus goes idle. Assumes one function (number 0) and target-only use.
module bus_target_decoder
    import bus_target_pkg::*;
#(
    parameter int AD_W   = 64,
    parameter int BE_W   = 4,
    parameter int FUNC_W = 3,
    parameter int IDX_W  = 6,
    localparam int LOW_W = 2 + IDX_W + FUNC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic              pci_x_mode,
    input  logic [AD_W-1:0]   ad,
    input  logic [BE_W-1:0]   cbe_n,
    output logic              claim,
    output logic [2:0]        op,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [BE_W-1:0]   byte_en
);

    logic             addr_edge, data_edge, end_edge, busy;
    logic             cfg_hit, accept;
    logic [IDX_W-1:0] cfg_idx;
    op_e              op_next;

    phase_tracker u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .addr_edge (addr_edge),
        .data_edge (data_edge),
        .end_edge  (end_edge),
        .busy      (busy)
    );

    cfg_addr_check #(.FUNC_W(FUNC_W), .IDX_W(IDX_W), .MY_FUNC(0)) u_cfg (
        .idsel   (idsel),
        .ad_low  (ad[LOW_W-1:0]),
        .cfg_hit (cfg_hit),
        .cfg_idx (cfg_idx)
    );

    cmd_classifier u_cls (
        .cmd     (cbe_n[3:0]),
        .pcix    (pci_x_mode),
        .cfg_hit (cfg_hit),
        .accept  (accept),
        .op      (op_next)
    );

    // Capture decode at the address edge; clear at idle.
    always_ff @(posedge clk) begin
        if (!rst_n || end_edge) begin
            claim   <= 1'b0;
            op      <= OP_NONE;
            reg_idx <= '0;
        end else if (addr_edge) begin
            claim   <= accept;
            op      <= op_next;
            reg_idx <= (accept && (op_next == OP_CFG_RD || op_next == OP_CFG_WR))
                       ? cfg_idx : '0;
        end
    end

    // Capture active-high byte lanes at the first data edge of a claimed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || end_edge) begin
            byte_en <= '0;
        end else if (data_edge && claim) begin
            byte_en <= ~cbe_n;
        end
    end

    AST_CLAIM_MEANS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (op != OP_NONE)); // R9
    AST_CFG_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(claim) && (op == OP_CFG_RD || op == OP_CFG_WR))
        |-> ($past(idsel) && $past(ad[1:0]) == 2'b00)); // R1
    AST_BLK_NEEDS_PCIX: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(claim) && (op == OP_BLK_RD || op == OP_BLK_WR))
        |-> $past(pci_x_mode)); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> ($stable(claim) && $stable(op) && $stable(reg_idx))); // R10
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && $past(frame_n) && $past(irdy_n)) |-> (!claim && byte_en == '0)); // R10
    AST_NO_LANES_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |-> (byte_en == '0)); // R4

endmodule

// File: tb/bus_target_decoder_bench.sv
module bus_target_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, pci_x_mode = 1'b0;
    logic [63:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        claim;
    logic [2:0]  op;
    logic [5:0]  reg_idx;
    logic [3:0]  byte_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_target_decoder u_bus_target_decoder (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .pci_x_mode(pci_x_mode), .ad(ad), .cbe_n(cbe_n),
        .claim(claim), .op(op), .reg_idx(reg_idx), .byte_en(byte_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference op per requirements R1,R2,R6,R7,R8,R9.
    function automatic int ref_op(input logic [3:0] c, input bit m, input bit sel, input logic [10:0] a);
        bit cfg_ok = sel && a[1:0] == 2'b00 && a[10:8] == 3'b000;
        case (c)
            4'b1010: return cfg_ok ? 1 : 0;
            4'b1011: return cfg_ok ? 2 : 0;
            4'b0111: return 3;
            4'b1110, 4'b1000: return m ? 4 : 0;
            4'b1111, 4'b1001: return m ? 5 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic txn(input logic [3:0] c, input bit m, input bit sel,
                       input logic [63:0] a, input logic [3:0] be, input int extra);
        int e_op = ref_op(c, m, sel, a[10:0]);
        int e_cl = (e_op != 0) ? 1 : 0;
        int e_ix = (e_op == 1 || e_op == 2) ? int'(a[7:2]) : 0;
        int e_be = e_cl ? int'(be) : 0;
        @(negedge clk);
        frame_n = 1'b0; ad = a; cbe_n = c; idsel = sel; pci_x_mode = m;
        @(negedge clk);
        chk(claim == e_cl, "R1/R2/R6/R8/R9 claim", claim, e_cl);
        chk(op == e_op, "R6/R7/R9 op", op, e_op);
        chk(reg_idx == e_ix, "R3 reg_idx", reg_idx, e_ix);
        cbe_n = ~be; irdy_n = 1'b0; frame_n = (extra == 0); ad = ~a;
        @(negedge clk);
        chk(byte_en == e_be, "R4 byte_en", byte_en, e_be);
        for (int k = 0; k < extra; k++) begin
            ad = {a[31:0], a[63:32]} ^ 64'(k); cbe_n = 4'(k); idsel = ~idsel;
            frame_n = (k == extra - 1);
            @(negedge clk);
            chk(claim == e_cl && op == e_op && reg_idx == e_ix && byte_en == e_be,
                "R10 hold", op, e_op);
        end
        irdy_n = 1'b1; frame_n = 1'b1;
        @(negedge clk);
        chk(claim == 0 && op == 0 && reg_idx == 0 && byte_en == 0, "R10 clear", claim, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(claim == 0 && op == 0 && reg_idx == 0 && byte_en == 0, "R11 reset", op, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 16; c++)
            for (int m = 0; m < 2; m++)
                for (int s = 0; s < 2; s++)
                    for (int t = 0; t < 6; t++) begin
                        logic [63:0] a;
                        a = {$urandom(), $urandom()};
                        a[10:8] = (t == 4) ? 3'b001 : (t == 5) ? 3'b111 : 3'b000;
                        a[1:0]  = (t < 4) ? 2'(t) : 2'b00;
                        txn(4'(c), m[0], s[0], a, 4'(c + t + 1), 0);
                    end
        // R5: upper address bits vary, results must match the reference.
        for (int h = 0; h < 8; h++)
            txn(4'b1010, 1'b0, 1'b1, {53'(h * 64'h1234_5678_9ABC), 11'h0FC}, 4'hA, 0);
        // R10: long transactions with changing bus lines.
        txn(4'b1011, 1'b1, 1'b1, 64'h0000_0000_0000_0088, 4'h5, 5);
        txn(4'b1001, 1'b1, 1'b0, 64'hFFFF_0000_1234_5670, 4'h3, 4);
        // R11: reset in the middle of a claimed transaction.
        @(negedge clk);
        frame_n = 1'b0; cbe_n = 4'b0111; ad = '0;
        @(negedge clk);
        chk(claim == 1, "R6 claim before reset", claim, 1);
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
        chk(claim == 0 && op == 0, "R11 mid reset", op, 0);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual 0 expected 1");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule